// File: doc/BRIEF.md
# Windowed Activity Monitor with Watermarks

The block watches several independent activity sources. Each source delivers a one-cycle pulse for every fixed batch of transactions. Each pulse adds a programmable weight to a per-channel accumulator. A shared divider counts millisecond strobes and closes a sampling period every programmed number of strobes. At that point every enabled channel takes its accumulator as the period's sample and clears the accumulator. It then folds the sample into a power-of-two exponential moving average.

Each channel checks the raw sample against a high and a low threshold. Separate hysteresis counters raise a flag only after a programmed number of periods in a row beyond a threshold. The new average is also checked against its own high and low band. Flags are sticky and cleared by writing ones. A channel's interrupt is the OR of its flags whose enables are set. A global status word gathers the interrupts of all channels. Software reaches every register through a simple register port, with a write strobe and combinational read data.

Top module: `act_mon`

## Requirements
- R1: After reset, the period register (0x4) reads 11, each channel's weight register reads 1024, and the average, status and global status all read 0. Every irq_o bit is low.
- R2: While a channel is active (control bit 31 enable and bit 18 sampling both set), each act_pulse_i cycle adds the weight register (offset 0x18) to its accumulator. At a period end the accumulator becomes the sample and restarts from zero.
- R3: The period register holds P. A period ends on every (P+1)-th tick_i strobe, and the average does not move on the P strobes before it.
- R4: At a period end an active channel sets avg = avg + ((sample - avg) >>> (K+1)), computed signed. K sits in control bits 12:10, so the window is 2^(K+1) samples. The average reads at offset 0x20.
- R5: A write to the initial-average register (offset 0xC) loads the average at once. That register reads back the value written.
- R6: With control bit 30 set, status bit 31 sets after N consecutive periods whose sample exceeds the high threshold (offset 0x4). N is control bits 28:26 plus one. The run count then restarts.
- R7: With control bit 29 set, status bit 30 sets after N consecutive periods whose sample is below the low threshold (offset 0x8). N is control bits 25:23 plus one.
- R8: A run count returns to zero when a sample falls back inside the thresholds. It also returns to zero while its enable bit or the channel enable is clear.
- R9: After an update, status bit 29 sets if avg exceeds the average-high register (0x10) and control bit 21 is set. Status bit 28 sets if avg is below the average-low register (0x14) and control bit 20 is set.
- R10: Writing the status register (offset 0x24) clears each bit written as one and leaves the others.
- R11: irq_o[i] is high exactly when a status bit is pending whose enable is set. The enables pair up as bit 31 with control bit 30, bit 30 with 29, bit 29 with 21, and bit 28 with 20. Clearing an enable hides the flag from irq_o but not from the status register.
- R12: Channel i occupies 0x100 + 0x40*i. The global status (0x0) shows irq_o[i] at bit 26-i. Control reads back its defined fields. A channel without enable ignores pulses and period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Millisecond strobe, one cycle wide |
| act_pulse_i | input | NUM_CH | Activity pulse per channel |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | NUM_CH | Interrupt per channel |

## Verification
The bench builds the block with NUM_CH=3 and the default 12-bit address, 1024 weight and 26 global top bit. It then shrinks the period register to 3 at run time, so each sampling period costs only four strobes. Two channels use different K values and run lengths: one with an above run of 1 and a below run of 3, the other with an above run of 2. This brings the run restart, the in-band reset and both average bands within a few dozen periods. The third channel stays unconfigured, so bit 24 of the global word and its interrupt must stay quiet throughout.

// File: rtl/act_mon_pkg.sv
package act_mon_pkg;
  localparam int REG_W     = 32;
  localparam int FLD_W     = 3;
  localparam int SPAN_LOG2 = 6;

  localparam logic [SPAN_LOG2-1:0] OFF_CTRL   = 6'h00;
  localparam logic [SPAN_LOG2-1:0] OFF_WM_HI  = 6'h04;
  localparam logic [SPAN_LOG2-1:0] OFF_WM_LO  = 6'h08;
  localparam logic [SPAN_LOG2-1:0] OFF_INIT   = 6'h0C;
  localparam logic [SPAN_LOG2-1:0] OFF_AVG_HI = 6'h10;
  localparam logic [SPAN_LOG2-1:0] OFF_AVG_LO = 6'h14;
  localparam logic [SPAN_LOG2-1:0] OFF_WEIGHT = 6'h18;
  localparam logic [SPAN_LOG2-1:0] OFF_AVG    = 6'h20;
  localparam logic [SPAN_LOG2-1:0] OFF_STATUS = 6'h24;

  localparam int B_EN  = 31;
  localparam int B_CUP = 30;
  localparam int B_CLO = 29;
  localparam int B_UPN = 26;
  localparam int B_LON = 23;
  localparam int B_AUP = 21;
  localparam int B_ALO = 20;
  localparam int B_PER = 18;
  localparam int B_K   = 10;

  typedef struct packed {
    logic             en;
    logic             cup;
    logic             clo;
    logic [FLD_W-1:0] up_n;
    logic [FLD_W-1:0] lo_n;
    logic             aup;
    logic             alo;
    logic             per;
    logic [FLD_W-1:0] k;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.en   = w[B_EN];
    c.cup  = w[B_CUP];
    c.clo  = w[B_CLO];
    c.up_n = w[B_UPN +: FLD_W];
    c.lo_n = w[B_LON +: FLD_W];
    c.aup  = w[B_AUP];
    c.alo  = w[B_ALO];
    c.per  = w[B_PER];
    c.k    = w[B_K +: FLD_W];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_EN]            = c.en;
    w[B_CUP]           = c.cup;
    w[B_CLO]           = c.clo;
    w[B_UPN +: FLD_W]  = c.up_n;
    w[B_LON +: FLD_W]  = c.lo_n;
    w[B_AUP]           = c.aup;
    w[B_ALO]           = c.alo;
    w[B_PER]           = c.per;
    w[B_K +: FLD_W]    = c.k;
    return w;
  endfunction
endpackage

// File: rtl/act_mon_ticker.sv
module act_mon_ticker #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                end_o
);
  logic [PERIOD_W-1:0] cnt_q;

  // >= keeps the divider live if the period shrinks mid-count
  assign end_o = tick_i && (cnt_q >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (end_o)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  a_r3_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/act_mon_hyst.sv
module act_mon_hyst #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             eval_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign fire_o = en_i && eval_i && hit_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i)             cnt_q <= '0;
    else if (eval_i) begin
      if (!hit_i || fire_o)     cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r8_run_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/act_mon_chan.sv
module act_mon_chan
  import act_mon_pkg::*;
#(
  parameter logic [REG_W-1:0] WEIGHT_RST = 32'd1024
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sel_i,
  input  logic                 we_i,
  input  logic [SPAN_LOG2-1:0] off_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic                 pulse_i,
  input  logic                 period_end_i,
  output logic [REG_W-1:0]     rdata_o,
  output logic                 irq_o
);
  ctrl_t            ctrl_q;
  logic [REG_W-1:0] wm_hi_q, wm_lo_q, init_q, avg_hi_q, avg_lo_q, weight_q;
  logic [REG_W-1:0] avg_q, acc_q;
  logic [3:0]       st_q;   // [3]=run high, [2]=run low, [1]=avg high, [0]=avg low

  logic wr, active, eval, init_wr, fire_up, fire_lo;
  logic [REG_W-1:0]      sample, avg_nxt;
  logic signed [REG_W:0] diff, step;
  logic [FLD_W:0]        shamt;
  logic [3:0]            st_set, st_clr, st_msk;

  assign wr      = sel_i && we_i;
  assign init_wr = wr && (off_i == OFF_INIT);
  assign active  = ctrl_q.en && ctrl_q.per;
  assign eval    = active && period_end_i;

  // a pulse in the closing cycle still belongs to the closing sample
  assign sample  = acc_q + ((pulse_i && active) ? weight_q : '0);
  assign shamt   = {1'b0, ctrl_q.k} + (FLD_W+1)'(1);
  assign diff    = $signed({1'b0, sample}) - $signed({1'b0, avg_q});
  assign step    = diff >>> shamt;
  assign avg_nxt = avg_q + step[REG_W-1:0];

  act_mon_hyst #(.CNT_W(FLD_W)) u_hyst_up (
    .clk_i, .rst_ni,
    .en_i   (ctrl_q.en && ctrl_q.cup),
    .eval_i (eval),
    .hit_i  (sample > wm_hi_q),
    .limit_i(ctrl_q.up_n),
    .fire_o (fire_up)
  );

  act_mon_hyst #(.CNT_W(FLD_W)) u_hyst_lo (
    .clk_i, .rst_ni,
    .en_i   (ctrl_q.en && ctrl_q.clo),
    .eval_i (eval),
    .hit_i  (sample < wm_lo_q),
    .limit_i(ctrl_q.lo_n),
    .fire_o (fire_lo)
  );

  assign st_set = {fire_up, fire_lo,
                   eval && ctrl_q.aup && (avg_nxt > avg_hi_q),
                   eval && ctrl_q.alo && (avg_nxt < avg_lo_q)};
  assign st_clr = (wr && off_i == OFF_STATUS) ? wdata_i[REG_W-1 -: 4] : 4'b0;
  assign st_msk = {ctrl_q.cup, ctrl_q.clo, ctrl_q.aup, ctrl_q.alo};
  assign irq_o  = |(st_q & st_msk);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      wm_hi_q  <= '0;
      wm_lo_q  <= '0;
      init_q   <= '0;
      avg_hi_q <= '0;
      avg_lo_q <= '0;
      weight_q <= WEIGHT_RST;
    end else if (wr) begin
      unique case (off_i)
        OFF_CTRL:   ctrl_q   <= ctrl_unpack(wdata_i);
        OFF_WM_HI:  wm_hi_q  <= wdata_i;
        OFF_WM_LO:  wm_lo_q  <= wdata_i;
        OFF_INIT:   init_q   <= wdata_i;
        OFF_AVG_HI: avg_hi_q <= wdata_i;
        OFF_AVG_LO: avg_lo_q <= wdata_i;
        OFF_WEIGHT: weight_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      avg_q <= '0;
      st_q  <= '0;
    end else begin
      if (!ctrl_q.en)                acc_q <= '0;
      else if (eval)                 acc_q <= '0;
      else if (pulse_i && active)    acc_q <= acc_q + weight_q;

      if (init_wr)                   avg_q <= wdata_i;
      else if (eval)                 avg_q <= avg_nxt;

      st_q <= (st_q & ~st_clr) | st_set;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      unique case (off_i)
        OFF_CTRL:   rdata_o = ctrl_pack(ctrl_q);
        OFF_WM_HI:  rdata_o = wm_hi_q;
        OFF_WM_LO:  rdata_o = wm_lo_q;
        OFF_INIT:   rdata_o = init_q;
        OFF_AVG_HI: rdata_o = avg_hi_q;
        OFF_AVG_LO: rdata_o = avg_lo_q;
        OFF_WEIGHT: rdata_o = weight_q;
        OFF_AVG:    rdata_o = avg_q;
        OFF_STATUS: rdata_o = {st_q, {(REG_W-4){1'b0}}};
        default:    rdata_o = '0;
      endcase
    end
  end

  a_r12_idle_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.en |=> acc_q == '0);
  a_r6_run_flag_on_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q[3]) |-> $past(period_end_i));
  a_r4_avg_moves_on_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(avg_q) |-> $past(eval || init_wr));
endmodule

// File: rtl/act_mon.sv
module act_mon
  import act_mon_pkg::*;
#(
  parameter int               NUM_CH      = 3,
  parameter int               ADDR_W      = 12,
  parameter int               PERIOD_W    = 8,
  parameter int               PERIOD_RST  = 11,
  parameter logic [REG_W-1:0] WEIGHT_RST  = 32'd1024,
  parameter int               GLB_TOP_BIT = 26,
  parameter int               CH_BASE     = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [NUM_CH-1:0] act_pulse_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int BLK_W    = ADDR_W - SPAN_LOG2;
  localparam int BASE_BLK = CH_BASE >> SPAN_LOG2;
  localparam logic [ADDR_W-1:0] A_GLB_ST  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_GLB_PER = ADDR_W'(4);

  logic [PERIOD_W-1:0] period_q;
  logic                period_end;
  logic [REG_W-1:0]    rd_ch [NUM_CH];
  logic [REG_W-1:0]    glb_st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            period_q <= PERIOD_W'(PERIOD_RST);
    else if (we_i && addr_i == A_GLB_PER)   period_q <= wdata_i[PERIOD_W-1:0];
  end

  act_mon_ticker #(.PERIOD_W(PERIOD_W)) u_ticker (
    .clk_i, .rst_ni, .tick_i,
    .period_i(period_q),
    .end_o   (period_end)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel;
    assign sel = (addr_i[ADDR_W-1:SPAN_LOG2] == BLK_W'(BASE_BLK + i));

    act_mon_chan #(.WEIGHT_RST(WEIGHT_RST)) u_chan (
      .clk_i, .rst_ni,
      .sel_i       (sel),
      .we_i,
      .off_i       (addr_i[SPAN_LOG2-1:0]),
      .wdata_i,
      .pulse_i     (act_pulse_i[i]),
      .period_end_i(period_end),
      .rdata_o     (rd_ch[i]),
      .irq_o       (irq_o[i])
    );
  end

  always_comb begin
    glb_st = '0;
    for (int i = 0; i < NUM_CH; i++) glb_st[GLB_TOP_BIT-i] = irq_o[i];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_GLB_ST)  rdata_o = glb_st;
    if (addr_i == A_GLB_PER) rdata_o = REG_W'(period_q);
    for (int i = 0; i < NUM_CH; i++) rdata_o = rdata_o | rd_ch[i];
  end
endmodule

// File: tb/act_mon_tb.sv
module act_mon_tb;
  localparam int NCH = 3;

  logic            clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, we = 1'b0;
  logic [NCH-1:0]  pulse = '0;
  logic [11:0]     addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NCH-1:0]  irq;

  always #5 clk = ~clk;

  act_mon #(.NUM_CH(NCH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .act_pulse_i(pulse),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;

  typedef struct {
    int          ch;
    string       tag;
    logic [31:0] avg;
    logic [31:0] st;
    logic [31:0] irq_b;
    logic [31:0] glb;
  } item_t;
  item_t sb_q[$];
  bit    mon_busy = 1'b0;

  // reference model
  logic [31:0] m_ctrl[NCH], m_wh[NCH], m_wl[NCH], m_ah[NCH], m_al[NCH];
  logic [31:0] m_w[NCH], m_avg[NCH], m_acc[NCH], m_st[NCH];
  int          m_uc[NCH], m_lc[NCH];
  int          m_per = 11, m_tc = 0;

  function automatic logic [11:0] ca(int ch, int off);
    return 12'(256 + 64*ch + off);
  endfunction

  function automatic logic [31:0] m_irq(int ch);
    logic [31:0] msk;
    msk = {m_ctrl[ch][30], m_ctrl[ch][29], m_ctrl[ch][21], m_ctrl[ch][20], 28'b0};
    return {31'b0, |(m_st[ch] & msk)};
  endfunction

  function automatic logic [31:0] m_glb();
    logic [31:0] g;
    g = '0;
    for (int c = 0; c < NCH; c++) g[26-c] = m_irq(c)[0];
    return g;
  endfunction

  function automatic bit m_active(int ch);
    return m_ctrl[ch][31] && m_ctrl[ch][18];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic cwr(int ch, int off, logic [31:0] d);
    wr(ca(ch, off), d);
    case (off)
      'h00: begin
        m_ctrl[ch] = d;
        if (!d[31]) m_acc[ch] = '0;
        if (!d[31] || !d[30]) m_uc[ch] = 0;
        if (!d[31] || !d[29]) m_lc[ch] = 0;
      end
      'h04: m_wh[ch] = d;
      'h08: m_wl[ch] = d;
      'h0C: m_avg[ch] = d;
      'h10: m_ah[ch] = d;
      'h14: m_al[ch] = d;
      'h18: m_w[ch] = d;
      'h24: m_st[ch] = m_st[ch] & ~d;
      default: ;
    endcase
  endtask

  task automatic pulses(int ch, int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk); pulse[ch] = 1'b1;
      @(negedge clk); pulse[ch] = 1'b0;
      if (m_active(ch)) m_acc[ch] = m_acc[ch] + m_w[ch];
    end
  endtask

  task automatic m_close(int ch);
    logic [31:0] smp, upn, lon;
    logic signed [32:0] diff, step;
    logic [31:0] set;
    if (!m_active(ch)) return;
    smp = m_acc[ch]; m_acc[ch] = '0;
    diff = $signed({1'b0, smp}) - $signed({1'b0, m_avg[ch]});
    step = diff >>> (int'(m_ctrl[ch][12:10]) + 1);
    m_avg[ch] = m_avg[ch] + step[31:0];
    upn = 32'(m_ctrl[ch][28:26]); lon = 32'(m_ctrl[ch][25:23]);
    set = '0;
    if (m_ctrl[ch][30]) begin
      if (smp > m_wh[ch]) begin
        if (m_uc[ch] == int'(upn)) begin set[31] = 1'b1; m_uc[ch] = 0; end
        else m_uc[ch]++;
      end else m_uc[ch] = 0;
    end
    if (m_ctrl[ch][29]) begin
      if (smp < m_wl[ch]) begin
        if (m_lc[ch] == int'(lon)) begin set[30] = 1'b1; m_lc[ch] = 0; end
        else m_lc[ch]++;
      end else m_lc[ch] = 0;
    end
    if (m_ctrl[ch][21] && m_avg[ch] > m_ah[ch]) set[29] = 1'b1;
    if (m_ctrl[ch][20] && m_avg[ch] < m_al[ch]) set[28] = 1'b1;
    m_st[ch] = m_st[ch] | set;
  endtask

  task automatic tick1();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    if (m_tc >= m_per) begin
      m_tc = 0;
      for (int c = 0; c < NCH; c++) m_close(c);
    end else m_tc++;
  endtask

  task automatic push(int ch, string tag);
    sb_q.push_back('{ch, tag, m_avg[ch], m_st[ch], m_irq(ch), m_glb()});
    wait (sb_q.size() == 0 && !mon_busy);
  endtask

  task automatic run(int p0, int p1, string tag);
    logic [31:0] d;
    pulses(0, p0);
    pulses(1, p1);
    repeat (m_per) tick1();
    rd(ca(0, 'h20), d); chk("R3 avg held before period end", d, m_avg[0]);
    tick1();
    push(0, tag);
    push(1, tag);
  endtask

  // monitor
  initial begin
    forever begin
      item_t it;
      logic [31:0] d;
      wait (sb_q.size() != 0);
      mon_busy = 1'b1;
      it = sb_q.pop_front();
      rd(ca(it.ch, 'h20), d); chk({"R2 R4 avg ", it.tag}, d, it.avg);
      rd(ca(it.ch, 'h24), d); chk({"status ", it.tag}, d, it.st);
      @(negedge clk); #1;     chk("R11 irq", {31'b0, irq[it.ch]}, it.irq_b);
      rd(12'h000, d);         chk("R12 global status", d, it.glb);
      mon_busy = 1'b0;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d, c0, c1;
    for (int c = 0; c < NCH; c++) begin
      m_ctrl[c] = '0; m_wh[c] = '0; m_wl[c] = '0; m_ah[c] = '0; m_al[c] = '0;
      m_w[c] = 32'd1024; m_avg[c] = '0; m_acc[c] = '0; m_st[c] = '0;
      m_uc[c] = 0; m_lc[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    rd(12'h004, d);     chk("R1 period reset", d, 32'd11);
    rd(ca(0,'h18), d);  chk("R1 weight reset", d, 32'd1024);
    rd(ca(1,'h20), d);  chk("R1 avg reset", d, 32'd0);
    rd(ca(0,'h24), d);  chk("R1 status reset", d, 32'd0);
    rd(12'h000, d);     chk("R1 global reset", d, 32'd0);
    chk("R1 irq reset", {29'b0, irq}, 32'd0);

    wr(12'h004, 32'd3); m_per = 3;
    rd(12'h004, d);     chk("R3 period readback", d, 32'd3);

    cwr(0, 'h18, 32'd16); cwr(0, 'h04, 32'd100); cwr(0, 'h08, 32'd20);
    cwr(0, 'h10, 32'd50); cwr(0, 'h14, 32'd10);
    c0 = (32'd1<<31)|(32'd1<<30)|(32'd1<<29)|(32'd2<<23)|(32'd1<<21)|(32'd1<<20)|(32'd1<<18)|(32'd1<<10);
    cwr(0, 'h00, c0);
    cwr(1, 'h18, 32'd1); cwr(1, 'h04, 32'd2);
    c1 = (32'd1<<31)|(32'd1<<30)|(32'd1<<26)|(32'd1<<18);
    cwr(1, 'h00, c1);
    rd(ca(0,'h00), d);  chk("R12 control readback", d, c0);

    run(10, 3, "R6");
    run(10, 3, "R6");
    cwr(0, 'h24, 32'hFFFF_FFFF); push(0, "R10");
    cwr(1, 'h24, 32'h8000_0000); push(1, "R10");

    run(0, 3, "R7");
    run(0, 0, "R7");
    run(0, 0, "R7");
    cwr(0, 'h24, 32'hFFFF_FFFF);

    run(0, 0, "R8");
    run(3, 0, "R8");
    run(0, 0, "R8");
    run(0, 0, "R8");
    run(0, 0, "R8");
    cwr(0, 'h24, 32'hFFFF_FFFF);
    cwr(0, 'h00, c0 & ~(32'd1<<29));
    run(0, 0, "R8");
    run(0, 0, "R8");
    run(0, 0, "R8");
    cwr(0, 'h24, 32'hFFFF_FFFF);

    cwr(0, 'h0C, 32'd5);
    rd(ca(0,'h20), d);  chk("R5 init loads avg", d, 32'd5);
    rd(ca(0,'h0C), d);  chk("R5 init readback", d, 32'd5);
    run(0, 0, "R9");
    cwr(0, 'h00, c0 & ~(32'd1<<29) & ~(32'd1<<20));
    push(0, "R11");

    cwr(0, 'h0C, 32'd1000);
    rd(ca(0,'h20), d);  chk("R5 init loads avg", d, 32'd1000);
    run(0, 0, "R9");

    cwr(1, 'h00, 32'd0);
    run(0, 5, "R12");
    rd(ca(2,'h20), d);  chk("R12 unused channel avg", d, 32'd0);
    chk("R12 unused channel irq", {31'b0, irq[2]}, 32'd0);

    finish_run();
  end
endmodule